// File: doc/BRIEF.md
# Cascaded Three-Controller Interrupt Priority Resolver

This block merges one master interrupt controller and two slave controllers, each with eight request inputs, into a single CPU interrupt line. The outputs of both slaves are wired permanently into master channels 2 and 5. Every request maps onto one of 22 priority levels. Level 1 is the most urgent. The block always presents the most urgent request that is unmasked, pending and not held off by a level already in service.

A mode input selects PC/AT-compatible operation. In that mode the second slave is bypassed, and master channel 5 becomes an ordinary request line at level 13. A single register-write port sets the three channel masks and the three 5-bit vector bases, and it also takes end-of-interrupt commands. The CPU acknowledges with a one-cycle pulse. On the next cycle the block returns an 8-bit vector and marks the winning level as in service.

Top module: `cascade_pic`

## Requirements
- R1: While reset is asserted, and after it is released, the CPU interrupt line is low, the winning level is 0, the vector-valid flag is low, no level is in service, every channel of all three controllers is masked, and all three vector bases are 0.
- R2: In normal mode the level numbers are assigned as follows. Master channel 0 is level 1 and master channel 1 is level 2. Slave-1 channel c is level 3+c. Master channels 3 and 4 are levels 11 and 12. Slave-2 channel c is level 13+c. Master channels 6 and 7 are levels 21 and 22. The winning level is the lowest-numbered eligible level, or 0 when no level is eligible.
- R3: Writing address 0, 1 or 2 loads the master, slave-1 or slave-2 mask byte. A 1 in bit c masks channel c, and a masked request never wins. Master mask bit 2 hides the whole slave-1 group. Master mask bit 5 hides the slave-2 group, or the direct line in PC/AT mode.
- R4: With the mode input high (PC/AT mode), master channel 5 is a direct request at level 13, slave-2 inputs are ignored, and levels 14 to 20 never win. Master request input 2 has no effect in either mode. Master request input 5 has no effect in normal mode.
- R5: An acknowledge pulse sets the in-service bit of the current winner. The vector-valid flag is high exactly in the cycle after an acknowledge. The vector is {base, channel}, where the channel is the one on the controller that owns the level and the base is that controller's base. Bases are written at address 3 (master), 4 (slave 1) and 5 (slave 2) from data bits 7:3.
- R6: A level that is in service holds off itself and every higher-numbered level, while lower-numbered levels can still win. The CPU interrupt line is high exactly when some level is eligible.
- R7: Writing address 6 with data bits 4:0 equal to a level from 1 to 22 clears that level's in-service bit. Any other value in those bits has no effect.
- R8: An acknowledge while no level is eligible returns the vector {master base, 3'b111} and sets no in-service bit.
- R9: When an acknowledge and an end-of-interrupt write fall in the same cycle, both take effect. The winner is judged on the in-service state from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_compat_i | input | 1 | 1 selects PC/AT mode (slave 2 bypassed) |
| mst_req_i | input | 8 | Master controller request lines |
| s1_req_i | input | 8 | Slave-1 request lines |
| s2_req_i | input | 8 | Slave-2 request lines |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address (0-2 masks, 3-5 bases, 6 end of interrupt) |
| wr_data_i | input | 8 | Register write data |
| ack_i | input | 1 | CPU acknowledge pulse |
| cpu_int_o | output | 1 | Interrupt request to the CPU |
| win_level_o | output | 5 | Winning level 1-22, 0 if none |
| vec_vld_o | output | 1 | Vector valid, one cycle after acknowledge |
| vector_o | output | 8 | Vector of the acknowledged request |

## Verification
An acknowledge and an end-of-interrupt write can land on the same clock edge. One sets an in-service bit and the other clears another, and their order decides which levels are held off next. Directed steps provoke this while a level is in service and a more urgent level is pending. Random steps repeat it with random levels. After each such edge the bench checks the returned vector and the next winning level against a reference model that applies the clear first and then the set. The model judges the winner on the state from before the edge.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int CH_N    = 8;
    localparam int CH_W    = $clog2(CH_N);
    localparam int DATA_W  = 8;
    localparam int BASE_W  = DATA_W - CH_W;
    localparam int LVL_N   = 22;
    localparam int LVL_W   = $clog2(LVL_N + 1);
    localparam int ADDR_W  = 3;

    // master channels fed by the slave outputs
    localparam int M_CAS1 = 2;
    localparam int M_CAS2 = 5;

    // level ranges occupied by the cascaded groups
    localparam int LVL_S1_FIRST = 3;
    localparam int LVL_S2_FIRST = 13;
    localparam int LVL_S2_LAST  = LVL_S2_FIRST + CH_N - 1;

    // register addresses
    localparam logic [ADDR_W-1:0] ADR_MSK_M = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_BASE0 = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_EOI   = 3'd6;

    localparam logic [CH_W-1:0] SPUR_CH = '1;

    typedef enum logic [1:0] {
        CTL_MST = 2'd0,
        CTL_SL1 = 2'd1,
        CTL_SL2 = 2'd2
    } ctl_e;

    typedef struct packed {
        ctl_e            ctl;
        logic [CH_W-1:0] ch;
    } src_t;

    // controller and channel that finally serve a given level
    function automatic src_t lvl_src(input logic [LVL_W-1:0] lvl, input logic compat);
        src_t s;
        s.ctl = CTL_MST;
        s.ch  = '0;
        if (lvl == 5'd2) begin
            s.ch = 3'd1;
        end else if (lvl >= 5'd3 && lvl <= 5'd10) begin
            s.ctl = CTL_SL1;
            s.ch  = CH_W'(lvl - 5'd3);
        end else if (lvl == 5'd11) begin
            s.ch = 3'd3;
        end else if (lvl == 5'd12) begin
            s.ch = 3'd4;
        end else if (lvl >= 5'd13 && lvl <= 5'd20) begin
            if (compat) begin
                s.ch = CH_W'(M_CAS2);
            end else begin
                s.ctl = CTL_SL2;
                s.ch  = CH_W'(lvl - 5'd13);
            end
        end else if (lvl == 5'd21) begin
            s.ch = 3'd6;
        end else if (lvl == 5'd22) begin
            s.ch = 3'd7;
        end
        return s;
    endfunction

    // bit i set for every level 1..lvl (bit i stands for level i+1)
    function automatic logic [LVL_N-1:0] upto_mask(input logic [LVL_W-1:0] lvl);
        logic [LVL_N-1:0] m;
        for (int i = 0; i < LVL_N; i++) begin
            m[i] = (LVL_W'(i) < lvl);
        end
        return m;
    endfunction
endpackage

// File: rtl/pic_regs.sv
module pic_regs
    import pic_pkg::*;
(
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          wr_en_i,
    input  logic [ADDR_W-1:0]             wr_addr_i,
    input  logic [DATA_W-1:0]             wr_data_i,
    output logic [CH_N-1:0]               mask_mst_o,
    output logic [CH_N-1:0]               mask_s1_o,
    output logic [CH_N-1:0]               mask_s2_o,
    output logic [BASE_W-1:0]             base_mst_o,
    output logic [BASE_W-1:0]             base_s1_o,
    output logic [BASE_W-1:0]             base_s2_o,
    output logic                          eoi_vld_o,
    output logic [LVL_W-1:0]              eoi_lvl_o
);
    localparam int CTL_N = 3;

    typedef struct packed {
        logic [CTL_N-1:0][CH_N-1:0]   msk;
        logic [CTL_N-1:0][BASE_W-1:0] base;
    } regs_t;

    localparam regs_t REGS_RST = '{msk: '1, base: '0};

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en_i) begin
            if (wr_addr_i < ADR_BASE0) begin
                regs_d.msk[2'(wr_addr_i)] = wr_data_i[CH_N-1:0];
            end else if (wr_addr_i < ADR_EOI) begin
                regs_d.base[2'(wr_addr_i - ADR_BASE0)] = wr_data_i[DATA_W-1 -: BASE_W];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            regs_q <= REGS_RST;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign mask_mst_o = regs_q.msk[0];
    assign mask_s1_o  = regs_q.msk[1];
    assign mask_s2_o  = regs_q.msk[2];
    assign base_mst_o = regs_q.base[0];
    assign base_s1_o  = regs_q.base[1];
    assign base_s2_o  = regs_q.base[2];

    assign eoi_lvl_o = wr_data_i[LVL_W-1:0];
    assign eoi_vld_o = wr_en_i && (wr_addr_i == ADR_EOI) &&
                       (eoi_lvl_o != '0) && (eoi_lvl_o <= LVL_W'(LVL_N));

    assert_mask_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i && wr_addr_i == ADR_MSK_M |=> mask_mst_o == $past(wr_data_i[CH_N-1:0]));
endmodule

// File: rtl/pic_level_map.sv
module pic_level_map
    import pic_pkg::*;
(
    input  logic              compat_i,
    input  logic [CH_N-1:0]   mst_req_i,
    input  logic [CH_N-1:0]   s1_req_i,
    input  logic [CH_N-1:0]   s2_req_i,
    input  logic [CH_N-1:0]   mask_mst_i,
    input  logic [CH_N-1:0]   mask_s1_i,
    input  logic [CH_N-1:0]   mask_s2_i,
    output logic [LVL_N-1:0]  pend_o
);
    logic [CH_N-1:0] s1_live, s2_live;
    logic            s1_open, s2_open, direct5;
    logic            unused_cas_in;

    assign s1_live = s1_req_i & ~mask_s1_i;
    assign s2_live = s2_req_i & ~mask_s2_i;
    assign s1_open = ~mask_mst_i[M_CAS1];
    assign s2_open = ~mask_mst_i[M_CAS2];
    assign direct5 = mst_req_i[M_CAS2] & s2_open;

    // channel 2 of the master is always the cascade input
    assign unused_cas_in = mst_req_i[M_CAS1];

    assign pend_o[0]  = mst_req_i[0] & ~mask_mst_i[0];
    assign pend_o[1]  = mst_req_i[1] & ~mask_mst_i[1];
    assign pend_o[10] = mst_req_i[3] & ~mask_mst_i[3];
    assign pend_o[11] = mst_req_i[4] & ~mask_mst_i[4];
    assign pend_o[20] = mst_req_i[6] & ~mask_mst_i[6];
    assign pend_o[21] = mst_req_i[7] & ~mask_mst_i[7];

    for (genvar c = 0; c < CH_N; c++) begin : g_s1
        assign pend_o[LVL_S1_FIRST - 1 + c] = s1_live[c] & s1_open;
    end

    for (genvar c = 0; c < CH_N; c++) begin : g_s2
        if (c == 0) begin : g_head
            assign pend_o[LVL_S2_FIRST - 1 + c] = compat_i ? direct5 : (s2_live[c] & s2_open);
        end else begin : g_tail
            assign pend_o[LVL_S2_FIRST - 1 + c] = ~compat_i & s2_live[c] & s2_open;
        end
    end
endmodule

// File: rtl/pic_prio_pick.sv
module pic_prio_pick #(
    parameter int N = pic_pkg::LVL_N,
    parameter int W = pic_pkg::LVL_W
) (
    input  logic [N-1:0] pend_i,
    input  logic [N-1:0] isr_i,
    output logic         hit_o,
    output logic [W-1:0] lvl_o
);
    logic [N-1:0] elig;
    logic         blk;

    always_comb begin
        blk  = 1'b0;
        elig = '0;
        for (int i = 0; i < N; i++) begin
            blk     = blk | isr_i[i];
            elig[i] = pend_i[i] & ~blk;
        end
        lvl_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig[i]) begin
                lvl_o = W'(i + 1);
            end
        end
    end

    assign hit_o = |elig;
endmodule

// File: rtl/cascade_pic.sv
module cascade_pic
    import pic_pkg::*;
(
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 mode_compat_i,
    input  logic [CH_N-1:0]      mst_req_i,
    input  logic [CH_N-1:0]      s1_req_i,
    input  logic [CH_N-1:0]      s2_req_i,
    input  logic                 wr_en_i,
    input  logic [ADDR_W-1:0]    wr_addr_i,
    input  logic [DATA_W-1:0]    wr_data_i,
    input  logic                 ack_i,
    output logic                 cpu_int_o,
    output logic [LVL_W-1:0]     win_level_o,
    output logic                 vec_vld_o,
    output logic [DATA_W-1:0]    vector_o
);
    typedef struct packed {
        logic [LVL_N-1:0]  isr;
        logic              vld;
        logic [DATA_W-1:0] vec;
    } state_t;

    localparam state_t STATE_RST = '{isr: '0, vld: 1'b0, vec: '0};

    logic [CH_N-1:0]   mask_mst, mask_s1, mask_s2;
    logic [BASE_W-1:0] base_mst, base_s1, base_s2, ack_base;
    logic              eoi_vld;
    logic [LVL_W-1:0]  eoi_lvl;
    logic [LVL_N-1:0]  pend;
    logic              hit;
    logic [LVL_W-1:0]  win;
    src_t              ack_src;
    state_t            st_d, st_q;

    pic_regs u_regs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .mask_mst_o (mask_mst),
        .mask_s1_o  (mask_s1),
        .mask_s2_o  (mask_s2),
        .base_mst_o (base_mst),
        .base_s1_o  (base_s1),
        .base_s2_o  (base_s2),
        .eoi_vld_o  (eoi_vld),
        .eoi_lvl_o  (eoi_lvl)
    );

    pic_level_map u_map (
        .compat_i   (mode_compat_i),
        .mst_req_i  (mst_req_i),
        .s1_req_i   (s1_req_i),
        .s2_req_i   (s2_req_i),
        .mask_mst_i (mask_mst),
        .mask_s1_i  (mask_s1),
        .mask_s2_i  (mask_s2),
        .pend_o     (pend)
    );

    pic_prio_pick #(.N(LVL_N), .W(LVL_W)) u_pick (
        .pend_i (pend),
        .isr_i  (st_q.isr),
        .hit_o  (hit),
        .lvl_o  (win)
    );

    assign ack_src = lvl_src(win, mode_compat_i);

    always_comb begin
        case (ack_src.ctl)
            CTL_SL1: ack_base = base_s1;
            CTL_SL2: ack_base = base_s2;
            default: ack_base = base_mst;
        endcase
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = ack_i;
        if (eoi_vld) begin
            st_d.isr[eoi_lvl - 5'd1] = 1'b0;
        end
        if (ack_i) begin
            if (hit) begin
                st_d.isr[win - 5'd1] = 1'b1;
                st_d.vec = {ack_base, ack_src.ch};
            end else begin
                st_d.vec = {base_mst, SPUR_CH};
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= STATE_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign cpu_int_o   = hit;
    assign win_level_o = win;
    assign vec_vld_o   = st_q.vld;
    assign vector_o    = st_q.vec;

    assert_winner_pending_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cpu_int_o |-> pend[win_level_o - 5'd1]);

    assert_idle_no_level_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cpu_int_o |-> win_level_o == '0);

    assert_inservice_blocks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cpu_int_o |-> (st_q.isr & upto_mask(win_level_o)) == '0);

    assert_compat_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode_compat_i |-> pend[LVL_S2_LAST-1:LVL_S2_FIRST] == '0);

    assert_ack_sets_isr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_i && cpu_int_o |=> st_q.isr[$past(win_level_o) - 5'd1]);

    assert_vld_follows_ack_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_i |=> vec_vld_o);

    assert_vld_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ack_i |=> !vec_vld_o);

    assert_eoi_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        eoi_vld && !(ack_i && cpu_int_o && win_level_o == eoi_lvl)
        |=> !st_q.isr[$past(eoi_lvl) - 5'd1]);

    assert_spurious_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_i && !cpu_int_o && !eoi_vld |=> st_q.isr == $past(st_q.isr) && vector_o[CH_W-1:0] == SPUR_CH);
endmodule

// File: tb/cascade_pic_tb.sv
`timescale 1ns/1ps
module cascade_pic_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode = 1'b0;
    logic [7:0] mreq = '0, s1r = '0, s2r = '0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       ack = 1'b0;
    logic       cpu_int, vec_vld;
    logic [4:0] win_level;
    logic [7:0] vector;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [7:0] mm_msk [3];
    logic [4:0] mm_base [3];
    bit   [22:0] m_isr;

    always #4 clk = ~clk;

    cascade_pic u_dut (
        .clk_i(clk), .rst_ni(rst_n), .mode_compat_i(mode),
        .mst_req_i(mreq), .s1_req_i(s1r), .s2_req_i(s2r),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .ack_i(ack), .cpu_int_o(cpu_int), .win_level_o(win_level),
        .vec_vld_o(vec_vld), .vector_o(vector)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic bit lvl_pend(int l);
        if (l == 1) return mreq[0] & ~mm_msk[0][0];
        if (l == 2) return mreq[1] & ~mm_msk[0][1];
        if (l >= 3 && l <= 10) return s1r[l-3] & ~mm_msk[1][l-3] & ~mm_msk[0][2];
        if (l == 11) return mreq[3] & ~mm_msk[0][3];
        if (l == 12) return mreq[4] & ~mm_msk[0][4];
        if (l >= 13 && l <= 20) begin
            if (mode) return (l == 13) & mreq[5] & ~mm_msk[0][5];
            return s2r[l-13] & ~mm_msk[2][l-13] & ~mm_msk[0][5];
        end
        if (l == 21) return mreq[6] & ~mm_msk[0][6];
        return mreq[7] & ~mm_msk[0][7];
    endfunction

    function automatic int exp_win();
        for (int l = 1; l <= 22; l++) begin
            if (m_isr[l]) return 0;
            if (lvl_pend(l)) return l;
        end
        return 0;
    endfunction

    function automatic logic [7:0] exp_vec(int l);
        if (l == 0) return {mm_base[0], 3'd7};
        if (l >= 3 && l <= 10) return {mm_base[1], 3'(l-3)};
        if (l >= 13 && l <= 20) return mode ? {mm_base[0], 3'd5} : {mm_base[2], 3'(l-13)};
        case (l)
            1: return {mm_base[0], 3'd0};
            2: return {mm_base[0], 3'd1};
            11: return {mm_base[0], 3'd3};
            12: return {mm_base[0], 3'd4};
            21: return {mm_base[0], 3'd6};
            default: return {mm_base[0], 3'd7};
        endcase
    endfunction

    task automatic step(string tag, bit a, bit w, logic [2:0] adr, logic [7:0] dat);
        int win;
        logic [7:0] ev;
        @(negedge clk);
        ack = a; wr_en = w; wr_addr = adr; wr_data = dat;
        #1;
        win = exp_win();
        chk({tag, " int"}, 32'(cpu_int), 32'(win != 0));
        chk({tag, " level"}, 32'(win_level), 32'(win));
        ev = exp_vec(win);
        @(posedge clk);
        #1;
        ack = 1'b0; wr_en = 1'b0;
        if (w) begin
            if (adr < 3) mm_msk[adr] = dat;
            else if (adr < 6) mm_base[adr-3] = dat[7:3];
            else if (adr == 6 && dat[4:0] >= 1 && dat[4:0] <= 22) m_isr[dat[4:0]] = 1'b0;
        end
        if (a && win != 0) m_isr[win] = 1'b1;
        @(negedge clk);
        chk({tag, " vld"}, 32'(vec_vld), 32'(a));
        if (a) chk({tag, " vec"}, 32'(vector), 32'(ev));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog R1 act=running exp=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd24681));
        for (int i = 0; i < 3; i++) begin mm_msk[i] = 8'hFF; mm_base[i] = '0; end
        m_isr = '0;
        mreq = 8'hFF; s1r = 8'hFF; s2r = 8'hFF;
        repeat (3) @(negedge clk);
        chk("R1 reset int", 32'(cpu_int), 0);
        chk("R1 reset level", 32'(win_level), 0);
        chk("R1 reset vld", 32'(vec_vld), 0);
        rst_n = 1'b1;
        step("R1", 0, 0, 0, 0);
        step("R8", 1, 0, 0, 0);

        // open all channels, set distinct bases
        step("R3", 0, 1, 3'd0, 8'h00);
        step("R3", 0, 1, 3'd1, 8'h00);
        step("R3", 0, 1, 3'd2, 8'h00);
        step("R5", 0, 1, 3'd3, 8'h08);
        step("R5", 0, 1, 3'd4, 8'h10);
        step("R5", 0, 1, 3'd5, 8'h18);
        step("R2", 0, 0, 0, 0);                       // all high: level 1
        mreq = 8'h00; s1r = 8'h80; s2r = 8'h01;
        step("R2", 0, 0, 0, 0);                       // level 10
        s1r = 8'h00; mreq = 8'h40;
        step("R2", 0, 0, 0, 0);                       // level 13
        mreq = 8'h24; s2r = 8'h00;
        step("R4", 0, 0, 0, 0);                       // master 2 and 5 ignored in normal mode

        // group masks
        s1r = 8'h0F; s2r = 8'h02; mreq = 8'h00;
        step("R3", 0, 1, 3'd0, 8'h04);
        step("R3", 0, 0, 0, 0);                       // slave 1 hidden: level 14
        step("R3", 0, 1, 3'd2, 8'h02);
        step("R3", 0, 0, 0, 0);                       // slave 2 all masked
        step("R3", 0, 1, 3'd0, 8'h00);
        step("R3", 0, 1, 3'd2, 8'h00);

        // compatibility mode
        mode = 1'b1; s1r = 8'h00; s2r = 8'hFF; mreq = 8'h00;
        step("R4", 0, 0, 0, 0);                       // slave 2 ignored
        mreq = 8'h20;
        step("R4", 1, 0, 0, 0);                       // level 13, vector {base0,5}
        step("R7", 0, 1, 3'd6, 8'd13);
        mode = 1'b0; mreq = 8'h00; s2r = 8'h00;

        // hold off and end of interrupt
        mreq = 8'h18;
        step("R6", 1, 0, 0, 0);                       // level 11 in service
        mreq = 8'h10;
        step("R6", 0, 0, 0, 0);                       // 12 blocked
        s1r = 8'h01;
        step("R6", 0, 0, 0, 0);                       // 3 wins
        s1r = 8'h00;
        step("R7", 0, 1, 3'd6, 8'd0);
        step("R7", 0, 1, 3'd6, 8'd23);
        step("R7", 0, 0, 0, 0);                       // still blocked
        step("R7", 0, 1, 3'd6, 8'd11);
        step("R7", 0, 0, 0, 0);                       // 12 wins

        // ack and end of interrupt in the same cycle
        s1r = 8'h02;
        step("R9", 1, 0, 0, 0);                       // level 4 in service
        mreq = 8'h02; s1r = 8'h00;
        step("R9", 1, 1, 3'd6, 8'd4);                 // ack level 2, clear 4
        mreq = 8'h00; s1r = 8'h02;
        step("R9", 0, 0, 0, 0);                       // 4 blocked by 2
        step("R9", 0, 1, 3'd6, 8'd2);
        step("R9", 0, 0, 0, 0);                       // 4 wins again

        for (int it = 0; it < 600; it++) begin
            int r;
            mreq = 8'($urandom); s1r = 8'($urandom); s2r = 8'($urandom);
            if ($urandom_range(0, 19) == 0) mode = ~mode;
            r = $urandom_range(0, 9);
            if (r < 4) step("R5", 1, 0, 0, 0);
            else if (r < 7) step("R7", 0, 1, 3'd6, 8'($urandom_range(0, 24)));
            else if (r == 7) step("R3", 0, 1, 3'($urandom_range(0, 5)), 8'($urandom) & 8'($urandom));
            else if (r == 8) step("R9", 1, 1, 3'd6, 8'($urandom_range(1, 22)));
            else step("R2", 0, 0, 0, 0);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule